// File: doc/BRIEF.md
# Data Link Bit-Stream Transmit Formatter

This block turns message bytes, taken from a show-ahead transmit FIFO, into the serial bit stream of a data link channel. A framer drives `bitEn` high on each clock cycle that carries one data link bit. The formatter emits exactly one bit for each such strobe and holds its state on every other cycle. A 2-bit mode input selects the output format. Two modes are bit-oriented HDLC framing: one with a hardware-generated 16-bit check sequence and one in which software supplies every byte between the flags. The other two modes are transparent and place either 8 or 6 bits of each FIFO byte on the link.

In the HDLC modes the block sends idle flags when no frame is waiting and opens a frame on a flag. It inserts zero bits after runs of ones inside the frame. It appends the check sequence in the FCS mode, and it closes the frame with a flag. It replaces the rest of a frame with an abort code when software asks for one, or when the FIFO empties before the end-of-frame byte arrives. The second case also pulses `underrun`. While `enable` is low the block does not touch the FIFO and sends marking ones.

Top module: `dlTxFormatter`

## Requirements
- R1: `mode` selects the format: 2'b00 is HDLC with check sequence, 2'b01 is HDLC without check sequence, 2'b10 is transparent with 8 bits per byte, and 2'b11 is transparent with 6 bits per byte. Each frame byte is consumed by exactly one `fifoRead` pulse.
- R2: In HDLC modes with no frame open, the link carries back-to-back 0x7E flags, sent LSB first. A flag that starts while `fifoValid` is high opens a frame, and the FIFO bytes follow that flag.
- R3: In HDLC modes a 0 is inserted after every five consecutive 1 bits of frame bytes and check-sequence bits. This includes a run of five that ends just before the closing flag. Flags and abort codes are never stuffed.
- R4: In mode 2'b00, the check sequence is the complemented CRC over the frame bytes. The CRC uses the reflected polynomial 0x8408, which is x^16+x^12+x^5+1 processed LSB first, with preset 0xFFFF. It is sent low byte first, LSB first, between the last byte (the one read with `fifoEof` high) and the closing flag.
- R5: In mode 2'b01, the closing flag follows the end-of-frame byte directly, and every FIFO byte is sent unchanged apart from stuffing.
- R6: An `abortReq` pulse while a frame is open makes the block finish the symbol in progress, then send eight 1 bits and close the frame. Flags follow, and no FIFO byte is read before the next flag.
- R7: In HDLC modes, if `fifoValid` is low when an open frame needs its next byte before end-of-frame, the block sends the abort code. `underrun` is high for exactly the one cycle after that strobe.
- R8: In the transparent modes, each byte is sent LSB first with no flags, stuffing or check sequence. Mode 2'b11 sends bits [5:0] and ignores bits [7:6]. With the FIFO empty, a 1 is sent on each strobe.
- R9: `txBit` changes only on the edge that ends a cycle with `bitEn` high, or on a disable. `fifoRead` is high only in a cycle with `bitEn`, `fifoValid` and `enable` all high.
- R10: While `enable` is low, `fifoRead` and `underrun` stay low and `txBit` is 1. Raising `enable` restarts formatting from a symbol boundary.
- R11: After reset, `txBit` is 1 and `fifoRead` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmit enable; low clears the formatter state |
| mode | input | 2 | Format select (see R1) |
| bitEn | input | 1 | Strobe marking a cycle that carries one link bit |
| fifoData | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifoValid | input | 1 | FIFO holds at least one byte |
| fifoEof | input | 1 | Head byte is the last byte of its frame |
| abortReq | input | 1 | Request to abort the open frame |
| txBit | output | 1 | Serial data link bit |
| fifoRead | output | 1 | Pops the head byte at this clock edge |
| underrun | output | 1 | One-cycle event: frame aborted on FIFO starvation |

## Verification
The assertions assume that `mode` only changes while `enable` is low. They also assume that the FIFO is show-ahead, so `fifoData` and `fifoEof` describe the head byte in the same cycle that `fifoRead` pops it. The bench changes `mode` and reloads its FIFO model only while the block is disabled. It advances its FIFO read pointer only on `fifoRead`. It spaces strobes by zero to two idle cycles, so that the bit stream can be compared with a reference built from the requirements.

// File: rtl/dltx_pkg.sv
package dltx_pkg;

  typedef enum logic [1:0] {
    MODE_FCS   = 2'b00,
    MODE_NOFCS = 2'b01,
    MODE_PACK8 = 2'b10,
    MODE_PACK6 = 2'b11
  } dlMode_e;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic clear;          // enable low: return to idle
    logic advance;        // emit one bit this cycle
    logic stuff;          // emit an inserted zero instead of a symbol bit
    logic ldData;         // load the FIFO head byte as the next symbol
    logic dataStuffable;  // loaded data byte takes part in zero insertion
    logic width6;         // loaded data byte is 6 bits wide
    logic ldFcs;          // load one check-sequence byte
    logic fcsHigh;        // pick the upper check-sequence byte
    logic ldFlag;         // load a flag symbol
    logic ldAbort;        // load an abort symbol
    logic ldFill;         // load a single idle one (transparent modes)
  } dlStrobe_t;

  localparam logic [7:0] FLAG_CODE  = 8'h7E;
  localparam logic [7:0] ABORT_CODE = 8'hFF;
  localparam int FCS_BYTES = 2;

endpackage

// File: rtl/dlTxDatapath.sv
module dlTxDatapath
  import dltx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PACK_W = 6,
  parameter int RUN_LEN = 5,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlStrobe_t         strobe,
  input  logic [BYTE_W-1:0] fifoData,
  output logic              txBit,
  output logic              symEmpty,
  output logic              runFull
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [BYTE_W-1:0] PACK_MASK = BYTE_W'((1 << PACK_W) - 1);

  logic [BYTE_W-1:0] sym;
  logic [CNT_W-1:0]  symLeft;
  logic              symStuffable;
  logic [RUN_W-1:0]  onesCnt;
  logic [CRC_W-1:0]  crc;
  logic              txBitQ;

  logic [BYTE_W-1:0] newSym;
  logic [CNT_W-1:0]  newLeft;
  logic              newStuffable;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] cIn,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cIn;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // Select the symbol whose next bit goes out: a freshly loaded one or the current.
  always_comb begin
    newSym = sym;
    newLeft = symLeft;
    newStuffable = symStuffable;
    if (strobe.ldData) begin
      newSym = strobe.width6 ? (fifoData & PACK_MASK) : fifoData;
      newLeft = strobe.width6 ? CNT_W'(PACK_W) : CNT_W'(BYTE_W);
      newStuffable = strobe.dataStuffable;
    end else if (strobe.ldFcs) begin
      newSym = strobe.fcsHigh ? ~crc[CRC_W-1 -: BYTE_W] : ~crc[BYTE_W-1:0];
      newLeft = CNT_W'(BYTE_W);
      newStuffable = 1'b1;
    end else if (strobe.ldFlag) begin
      newSym = FLAG_CODE;
      newLeft = CNT_W'(BYTE_W);
      newStuffable = 1'b0;
    end else if (strobe.ldAbort) begin
      newSym = ABORT_CODE;
      newLeft = CNT_W'(BYTE_W);
      newStuffable = 1'b0;
    end else if (strobe.ldFill) begin
      newSym = '1;
      newLeft = CNT_W'(1);
      newStuffable = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sym <= '0;
      symLeft <= '0;
      symStuffable <= 1'b0;
      onesCnt <= '0;
      crc <= CRC_INIT;
      txBitQ <= 1'b1;
    end else if (strobe.clear) begin
      sym <= '0;
      symLeft <= '0;
      symStuffable <= 1'b0;
      onesCnt <= '0;
      crc <= CRC_INIT;
      txBitQ <= 1'b1;
    end else begin
      if (strobe.ldData) crc <= crcByte(crc, fifoData);
      else if (strobe.ldFlag) crc <= CRC_INIT;
      if (strobe.advance) begin
        if (strobe.stuff) begin
          txBitQ <= 1'b0;
          onesCnt <= '0;
        end else begin
          txBitQ <= newSym[0];
          sym <= newSym >> 1;
          symLeft <= newLeft - 1'b1;
          symStuffable <= newStuffable;
          if (newStuffable && newSym[0]) onesCnt <= onesCnt + 1'b1;
          else onesCnt <= '0;
        end
      end
    end
  end

  assign txBit = txBitQ;
  assign symEmpty = (symLeft == '0);
  assign runFull = (onesCnt == RUN_W'(RUN_LEN));

endmodule

// File: rtl/dlTxCtrl.sv
module dlTxCtrl
  import dltx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       bitEn,
  input  logic       fifoValid,
  input  logic       fifoEof,
  input  logic       abortReq,
  input  logic       symEmpty,
  input  logic       runFull,
  output dlStrobe_t  strobe,
  output logic       fifoRead,
  output logic       underrun
);

  localparam int FI_W = $clog2(FCS_BYTES + 1);

  logic            inFrame;
  logic            eofSeen;
  logic [FI_W-1:0] fcsIdx;
  logic            abortPending;
  logic            underrunQ;

  logic hdlc;
  logic active;
  logic boundary;
  logic urEvent;

  always_comb begin
    strobe = '0;
    fifoRead = 1'b0;
    urEvent = 1'b0;
    hdlc = (mode == MODE_FCS) || (mode == MODE_NOFCS);
    active = enable && bitEn;
    boundary = active && !runFull && symEmpty;
    strobe.clear = !enable;
    strobe.advance = active;
    strobe.stuff = active && runFull;
    strobe.width6 = (mode == MODE_PACK6);
    strobe.dataStuffable = hdlc;
    strobe.fcsHigh = (fcsIdx != '0);
    if (boundary) begin
      if (hdlc) begin
        if (inFrame && (abortPending || abortReq)) begin
          strobe.ldAbort = 1'b1;
        end else if (inFrame && !eofSeen) begin
          if (fifoValid) begin
            strobe.ldData = 1'b1;
            fifoRead = 1'b1;
          end else begin
            strobe.ldAbort = 1'b1;
            urEvent = 1'b1;
          end
        end else if (inFrame && (mode == MODE_FCS) && (fcsIdx < FI_W'(FCS_BYTES))) begin
          strobe.ldFcs = 1'b1;
        end else begin
          strobe.ldFlag = 1'b1;
        end
      end else if (fifoValid) begin
        strobe.ldData = 1'b1;
        fifoRead = 1'b1;
      end else begin
        strobe.ldFill = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      eofSeen <= 1'b0;
      fcsIdx <= '0;
      abortPending <= 1'b0;
      underrunQ <= 1'b0;
    end else if (!enable) begin
      inFrame <= 1'b0;
      eofSeen <= 1'b0;
      fcsIdx <= '0;
      abortPending <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      underrunQ <= urEvent;
      if (strobe.ldAbort || strobe.ldFlag) abortPending <= 1'b0;
      else if (abortReq && inFrame) abortPending <= 1'b1;
      if (strobe.ldFlag) begin
        inFrame <= fifoValid;
        eofSeen <= 1'b0;
        fcsIdx <= '0;
      end else if (strobe.ldAbort) begin
        inFrame <= 1'b0;
      end
      if (strobe.ldData && hdlc) eofSeen <= fifoEof;
      if (strobe.ldFcs) fcsIdx <= fcsIdx + 1'b1;
    end
  end

  assign underrun = underrunQ;

endmodule

// File: rtl/dlTxFormatter.sv
module dlTxFormatter
  import dltx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PACK_W = 6,
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              bitEn,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              fifoValid,
  input  logic              fifoEof,
  input  logic              abortReq,
  output logic              txBit,
  output logic              fifoRead,
  output logic              underrun
);

  dlStrobe_t strobe;
  logic symEmpty;
  logic runFull;

  dlTxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .bitEn(bitEn),
    .fifoValid(fifoValid), .fifoEof(fifoEof), .abortReq(abortReq),
    .symEmpty(symEmpty), .runFull(runFull), .strobe(strobe),
    .fifoRead(fifoRead), .underrun(underrun)
  );

  dlTxDatapath #(.BYTE_W(BYTE_W), .PACK_W(PACK_W), .RUN_LEN(RUN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoData(fifoData),
    .txBit(txBit), .symEmpty(symEmpty), .runFull(runFull)
  );

endmodule

// File: rtl/dlTxChecker.sv
module dlTxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [1:0] mode,
  input logic       bitEn,
  input logic       fifoValid,
  input logic       txBit,
  input logic       fifoRead,
  input logic       underrun
);

  // R9: a pop only happens on a strobe with data present while enabled
  assert_read_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> (bitEn && fifoValid && enable));

  // R9: without a strobe the serial bit holds
  assert_bit_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && enable) |=> $stable(txBit));

  // R10: disabled link marks with ones and never pops
  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> txBit);

  assert_no_read_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !fifoRead);

  // R7: underrun is a single-cycle event, only in HDLC modes, caused by a starved strobe
  assert_underrun_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);

  assert_underrun_hdlc_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (mode == 2'b00 || mode == 2'b01));

  assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> ($past(bitEn) && !$past(fifoValid) && $past(enable)));

endmodule

bind dlTxFormatter dlTxChecker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .bitEn(bitEn),
  .fifoValid(fifoValid), .txBit(txBit), .fifoRead(fifoRead), .underrun(underrun)
);

// File: tb/sim_dlTxFormatter.sv
`timescale 1ns/1ps
module sim_dlTxFormatter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, enable, bitEn, abortReq, fifoClr, eofOnLast;
  logic [1:0] mode;
  logic [7:0] fifoData;
  logic fifoValid, fifoEof, txBit, fifoRead, underrun;

  logic [7:0] fmem [16];
  int fifoCnt;
  logic [4:0] rdPtr;

  int checks = 0;
  int fails = 0;
  logic expBits [512];
  int expLen;
  int run;
  logic holdErr;
  logic lastUr;

  assign fifoValid = (int'(rdPtr) < fifoCnt);
  assign fifoData  = fifoValid ? fmem[rdPtr[3:0]] : 8'h00;
  assign fifoEof   = eofOnLast && (int'(rdPtr) == fifoCnt - 1);

  always @(posedge clk) begin
    if (fifoClr) rdPtr <= '0;
    else if (fifoRead) rdPtr <= rdPtr + 1'b1;
  end

  dlTxFormatter u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .bitEn(bitEn),
    .fifoData(fifoData), .fifoValid(fifoValid), .fifoEof(fifoEof),
    .abortReq(abortReq), .txBit(txBit), .fifoRead(fifoRead), .underrun(underrun)
  );

  // {mode, byte count, bytes with byte 0 in bits [7:0]}
  localparam logic [36:0] VECS [7] = '{
    {2'b00, 3'd3, 32'h00563412},
    {2'b00, 3'd2, 32'h00007EFF},
    {2'b01, 3'd2, 32'h0000FFFF},
    {2'b01, 3'd3, 32'h007E00F8},
    {2'b10, 3'd2, 32'h00007EFF},
    {2'b11, 3'd3, 32'h0040FFC1},
    {2'b00, 3'd1, 32'h000000F8}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addBits(input logic [7:0] b, input int w, input logic stuffIt);
    for (int i = 0; i < w; i++) begin
      expBits[expLen] = b[i];
      expLen++;
      if (stuffIt) begin
        if (b[i]) run++;
        else run = 0;
        if (run == 5) begin
          expBits[expLen] = 1'b0;
          expLen++;
          run = 0;
        end
      end else begin
        run = 0;
      end
    end
  endtask

  function automatic logic [15:0] crcOf(input int n);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ fmem[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  task automatic strobeBit(output logic b, input int gap);
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    b = txBit;
    lastUr = underrun;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (txBit !== b) holdErr = 1'b1;
    end
  endtask

  task automatic restart(input logic [1:0] m);
    enable = 1'b0;
    fifoClr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mode = m;
    fifoClr = 1'b0;
    expLen = 0;
    run = 0;
    holdErr = 1'b0;
  endtask

  task automatic compareStream(input string req, input int gap);
    logic b;
    for (int k = 0; k < expLen; k++) begin
      strobeBit(b, gap);
      check(b === expBits[k], req, int'(b), int'(expBits[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic b;
    logic urSeen;
    int urIdx;
    logic [15:0] c;
    rstN = 1'b0; enable = 1'b0; bitEn = 1'b0; abortReq = 1'b0;
    fifoClr = 1'b1; eofOnLast = 1'b1; mode = 2'b00; fifoCnt = 0;
    for (int i = 0; i < 16; i++) fmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(txBit === 1'b1, "R11 txBit", int'(txBit), 1);
    check(fifoRead === 1'b0, "R11 fifoRead", int'(fifoRead), 0);
    check(underrun === 1'b0, "R11 underrun", int'(underrun), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10 disabled: strobes with data waiting do nothing
    restart(2'b01);
    fmem[0] = 8'h00; fmem[1] = 8'h55; fmem[2] = 8'hAA; fifoCnt = 3;
    urSeen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      bitEn = 1'b1;
      if (fifoRead) urSeen = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      if (txBit !== 1'b1 || underrun !== 1'b0) urSeen = 1'b1;
      @(negedge clk);
    end
    check(urSeen === 1'b0, "R10 outputs while disabled", int'(urSeen), 0);
    check(rdPtr == 5'd0, "R10 no pop while disabled", int'(rdPtr), 0);

    // R2 idle flags
    restart(2'b00);
    fifoCnt = 0;
    addBits(8'h7E, 8, 1'b0); addBits(8'h7E, 8, 1'b0);
    enable = 1'b1;
    compareStream("R2 idle flag", 1);

    // Table of frames: R1 R3 R4 R5 R8
    for (int v = 0; v < 7; v++) begin
      restart(VECS[v][36:35]);
      fifoCnt = int'(VECS[v][34:32]);
      eofOnLast = 1'b1;
      for (int k = 0; k < fifoCnt; k++) fmem[k] = VECS[v][8*k +: 8];
      if (!mode[1]) begin
        addBits(8'h7E, 8, 1'b0);
        for (int k = 0; k < fifoCnt; k++) addBits(fmem[k], 8, 1'b1);
        if (mode == 2'b00) begin
          c = ~crcOf(fifoCnt);
          addBits(c[7:0], 8, 1'b1);
          addBits(c[15:8], 8, 1'b1);
        end
        addBits(8'h7E, 8, 1'b0);
        addBits(8'h7E, 8, 1'b0);
      end else begin
        for (int k = 0; k < fifoCnt; k++) addBits(fmem[k], mode[0] ? 6 : 8, 1'b0);
        addBits(8'hFF, 4, 1'b0);
      end
      enable = 1'b1;
      compareStream(mode == 2'b00 ? "R4 R3 fcs frame" :
                    mode == 2'b01 ? "R5 R3 plain frame" : "R8 transparent", v % 3);
      check(holdErr === 1'b0, "R9 hold between strobes", int'(holdErr), 0);
      check(int'(rdPtr) == fifoCnt, "R1 bytes consumed", int'(rdPtr), fifoCnt);
    end

    // R6 abort request during the opening flag
    restart(2'b01);
    fmem[0] = 8'h00; fmem[1] = 8'h00; fmem[2] = 8'h00; fmem[3] = 8'h00;
    fifoCnt = 4; eofOnLast = 1'b1;
    addBits(8'h7E, 8, 1'b0); addBits(8'hFF, 8, 1'b0); addBits(8'h7E, 8, 1'b0);
    enable = 1'b1;
    urSeen = 1'b0;
    for (int k = 0; k < expLen; k++) begin
      strobeBit(b, 1);
      if (lastUr) urSeen = 1'b1;
      check(b === expBits[k], "R6 abort stream", int'(b), int'(expBits[k]));
      if (k == 1) begin
        abortReq = 1'b1;
        @(negedge clk);
        abortReq = 1'b0;
      end
    end
    check(rdPtr == 5'd0, "R6 no read before next flag", int'(rdPtr), 0);
    check(urSeen === 1'b0, "R6 no underrun on request", int'(urSeen), 0);

    // R7 underrun: frame without end marker
    restart(2'b01);
    fmem[0] = 8'h00; fifoCnt = 1; eofOnLast = 1'b0;
    addBits(8'h7E, 8, 1'b0); addBits(8'h00, 8, 1'b1);
    addBits(8'hFF, 8, 1'b0); addBits(8'h7E, 8, 1'b0);
    enable = 1'b1;
    urIdx = -1;
    for (int k = 0; k < expLen; k++) begin
      strobeBit(b, 1);
      if (lastUr && urIdx < 0) urIdx = k;
      else if (lastUr) urIdx = 99;
      check(b === expBits[k], "R7 underrun stream", int'(b), int'(expBits[k]));
    end
    check(urIdx == 16, "R7 underrun pulse position", urIdx, 16);
    check(underrun === 1'b0, "R7 underrun cleared", int'(underrun), 0);

    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(txBit === 1'b1, "R10 marking after disable", int'(txBit), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule